// File: doc/BRIEF.md
# Cluster Barrier Rendezvous Unit

This unit lets the cores of one cluster meet at any of several numbered hardware barriers. A core sends a single arrival request once all of its own active warps have reached the barrier locally. The request names the barrier, gives the participant total minus one, and carries the sender's core number. That number may be global: the unit reduces it modulo the cluster's core count to pick a bit. For each barrier the unit keeps an arrival bitmask with one bit per core.

Each request brings its own participant total, so no count is fixed in hardware. The unit works out what the mask will hold once the new arrival is added. If the number of set bits then equals the requested total, that arrival completes the barrier in the same cycle it is accepted. On the next clock edge the unit emits a one-cycle release pulse. The pulse carries the barrier number and a per-core release mask that names exactly the cores that arrived. The barrier's mask is cleared at the same time, so the next round can begin at once. Cores whose bits are clear in the release mask keep waiting.

Top module: `clu_barrier_sync`

## Requirements
- R1: Synchronous active-high reset clears every arrival mask and holds `rel_valid` low. An arrival recorded before reset does not count toward any barrier after reset.
- R2: `req_ready` is low while reset is asserted and high from the first clock edge after reset is released. At most one request is accepted per cycle, on a clock edge where `req_valid` and `req_ready` are both high.
- R3: The core number is reduced modulo NUM_CORES, and the result selects the mask bit: bit i stands for local core i. With 4 cores, core 5 maps to bit 1, core 10 to bit 2 and core 255 to bit 3.
- R4: An accepted arrival that is not a duplicate and does not complete its barrier sets the sender's bit and produces no release.
- R5: When the set-bit count of the addressed mask, including the new arrival, equals `req_size_m1 + 1`, `rel_valid` is high for exactly the one cycle after the accepting edge. In that cycle `rel_bar` is the barrier number and `rel_mask` has set exactly the bits of the cores that arrived.
- R6: A completed barrier's mask is cleared together with its release, so the next round on that barrier starts from an empty mask.
- R7: Barriers are independent. Arrivals at one barrier never change another barrier's mask. A request accepted in the cycle where a different barrier's release is being presented is recorded normally.
- R8: An arrival from a core whose bit is already set in the addressed mask is ignored. It leaves the mask unchanged and produces no release, whatever its `req_size_m1` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Arrival request strobe |
| req_ready | output | 1 | Unit can accept an arrival this cycle |
| req_bar | input | BAR_W | Barrier number of the arrival |
| req_size_m1 | input | SZ_W | Participant total minus one |
| req_core | input | CORE_ID_W | Sender core number (global allowed) |
| rel_valid | output | 1 | One-cycle release pulse |
| rel_bar | output | BAR_W | Barrier being released |
| rel_mask | output | NUM_CORES | Cores to resume, bit i = local core i |

## Verification
Three patterns separate the ways the completion test can go wrong. A full three-core rendezvous separates "release on the last arrival" from an early or late release. A duplicate arrival whose participant total would already be met separates true duplicate suppression from a popcount that double-counts. Core numbers above the core count, such as 5, 10 and 255, show whether the modulo folding picks the right bits. Back-to-back releases of two barriers, and a four-core burst with no idle cycles, show whether the barriers stay isolated and whether a request that arrives while another barrier's release is on the outputs is still recorded. A pending arrival made before a reset, followed by a one-core barrier after the reset, shows whether stale bits survive the reset.

// File: rtl/clu_bar_pkg.sv
package clu_bar_pkg;

  // Outcome of evaluating one arrival against its barrier's mask
  typedef enum logic [1:0] {
    ARR_RECORD   = 2'd0,  // new bit, target not yet met
    ARR_DUP      = 2'd1,  // bit already set, ignored
    ARR_COMPLETE = 2'd2   // new bit meets target, release
  } arr_act_e;

endpackage

// File: rtl/clu_bar_slot_map.sv
module clu_bar_slot_map #(
  parameter int NUM_CORES = 4,
  parameter int CORE_ID_W = 8
) (
  input  logic [CORE_ID_W-1:0] core_id,
  output logic [NUM_CORES-1:0] slot_bit
);

  // fold a global core number onto the cluster's local slots
  logic [CORE_ID_W-1:0] local_id;
  assign local_id = core_id % CORE_ID_W'(NUM_CORES);

  for (genvar s = 0; s < NUM_CORES; s++) begin : g_slot
    assign slot_bit[s] = (local_id == CORE_ID_W'(s));
  end

endmodule

// File: rtl/clu_bar_mask_bank.sv
module clu_bar_mask_bank #(
  parameter int NUM_CORES    = 4,
  parameter int NUM_BARRIERS = 8,
  parameter int BAR_W        = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [BAR_W-1:0]     wr_bar,
  input  logic [NUM_CORES-1:0] wr_mask,
  input  logic [BAR_W-1:0]     rd_bar,
  output logic [NUM_CORES-1:0] rd_mask
);

  logic [NUM_CORES-1:0] slot_q [NUM_BARRIERS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NUM_BARRIERS; b++) slot_q[b] <= '0;
    end else if (wr_en) begin
      slot_q[wr_bar] <= wr_mask;
    end
  end

  assign rd_mask = slot_q[rd_bar];

  // per-barrier occupancy, used by the reset check below
  logic [NUM_BARRIERS-1:0] busy;
  for (genvar b = 0; b < NUM_BARRIERS; b++) begin : g_busy
    assign busy[b] = |slot_q[b];
  end

  AST_BANK_EMPTY_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (busy == '0)); // R1

endmodule

// File: rtl/clu_bar_judge.sv
module clu_bar_judge
  import clu_bar_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int SZ_W      = 2
) (
  input  logic [NUM_CORES-1:0] cur_mask,
  input  logic [NUM_CORES-1:0] arr_bit,
  input  logic [SZ_W-1:0]      size_m1,
  output arr_act_e             act,
  output logic [NUM_CORES-1:0] merged
);

  localparam int CNT_W = SZ_W + 1;

  logic [CNT_W-1:0] ones;
  logic [CNT_W-1:0] target;
  logic             dup;

  always_comb begin
    merged = cur_mask | arr_bit;
    ones   = '0;
    for (int i = 0; i < NUM_CORES; i++) ones = ones + CNT_W'(merged[i]);
    target = CNT_W'(size_m1) + CNT_W'(1);
    dup    = |(cur_mask & arr_bit);
    if (dup)                 act = ARR_DUP;
    else if (ones == target) act = ARR_COMPLETE;
    else                     act = ARR_RECORD;
  end

endmodule

// File: rtl/clu_barrier_sync.sv
module clu_barrier_sync
  import clu_bar_pkg::*;
#(
  parameter  int NUM_CORES    = 4,
  parameter  int NUM_BARRIERS = 8,
  parameter  int CORE_ID_W    = 8,
  localparam int BAR_W        = (NUM_BARRIERS > 1) ? $clog2(NUM_BARRIERS) : 1,
  localparam int SZ_W         = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [BAR_W-1:0]     req_bar,
  input  logic [SZ_W-1:0]      req_size_m1,
  input  logic [CORE_ID_W-1:0] req_core,
  output logic                 rel_valid,
  output logic [BAR_W-1:0]     rel_bar,
  output logic [NUM_CORES-1:0] rel_mask
);

  logic                 ready_q;
  logic                 accept;
  logic [NUM_CORES-1:0] arr_bit;
  logic [NUM_CORES-1:0] cur_mask;
  logic [NUM_CORES-1:0] merged;
  logic [NUM_CORES-1:0] wr_mask;
  logic                 wr_en;
  arr_act_e             act;

  assign accept    = req_valid && ready_q;
  assign req_ready = ready_q;

  clu_bar_slot_map #(
    .NUM_CORES (NUM_CORES),
    .CORE_ID_W (CORE_ID_W)
  ) u_slot_map (
    .core_id  (req_core),
    .slot_bit (arr_bit)
  );

  clu_bar_mask_bank #(
    .NUM_CORES    (NUM_CORES),
    .NUM_BARRIERS (NUM_BARRIERS),
    .BAR_W        (BAR_W)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_bar  (req_bar),
    .wr_mask (wr_mask),
    .rd_bar  (req_bar),
    .rd_mask (cur_mask)
  );

  clu_bar_judge #(
    .NUM_CORES (NUM_CORES),
    .SZ_W      (SZ_W)
  ) u_judge (
    .cur_mask (cur_mask),
    .arr_bit  (arr_bit),
    .size_m1  (req_size_m1),
    .act      (act),
    .merged   (merged)
  );

  // duplicates never write; completion writes an empty mask
  assign wr_en   = accept && (act != ARR_DUP);
  assign wr_mask = (act == ARR_COMPLETE) ? '0 : merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q   <= 1'b0;
      rel_valid <= 1'b0;
      rel_bar   <= '0;
      rel_mask  <= '0;
    end else begin
      ready_q   <= 1'b1;
      rel_valid <= accept && (act == ARR_COMPLETE);
      if (accept && (act == ARR_COMPLETE)) begin
        rel_bar  <= req_bar;
        rel_mask <= merged;
      end
    end
  end

  AST_REL_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> $past(req_valid && req_ready)); // R5

  AST_REL_BAR_MATCH: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> (rel_bar == $past(req_bar))); // R5

  AST_REL_COUNT_MATCH: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> ($countones(rel_mask) == int'($past(req_size_m1)) + 1)); // R5

  AST_DUP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (accept && act == ARR_DUP) |=> !rel_valid); // R8

endmodule

// File: tb/clu_barrier_sync_tb.sv
`timescale 1ns/1ps
module clu_barrier_sync_tb;

  localparam int NC  = 4;
  localparam int NB  = 8;
  localparam int CW  = 8;
  localparam int BW  = 3;
  localparam int SW  = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [BW-1:0] req_bar = '0;
  logic [SW-1:0] req_size_m1 = '0;
  logic [CW-1:0] req_core = '0;
  logic          rel_valid;
  logic [BW-1:0] rel_bar;
  logic [NC-1:0] rel_mask;

  always #2.5 clk = ~clk;

  clu_barrier_sync #(.NUM_CORES(NC), .NUM_BARRIERS(NB), .CORE_ID_W(CW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_bar(req_bar), .req_size_m1(req_size_m1), .req_core(req_core),
    .rel_valid(rel_valid), .rel_bar(rel_bar), .rel_mask(rel_mask)
  );

  typedef struct {
    int    bar;
    int    mask;
    int    due;
    string tag;
  } exp_t;

  exp_t          sb_q[$];
  logic [NC-1:0] model [NB];
  int            cyc = 0;
  int            n_cmp = 0;
  int            n_bad = 0;
  bit            done = 0;
  string         quiet_tag = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // monitor: compares each cycle against the scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rel_valid) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, quiet_tag, "unexpected release mask", int'(rel_mask), 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(int'(rel_bar) == e.bar, e.tag, "release barrier", int'(rel_bar), e.bar);
          chk(int'(rel_mask) == e.mask, e.tag, "release mask", int'(rel_mask), e.mask);
          chk(cyc == e.due, e.tag, "release cycle", cyc, e.due);
        end
      end else if (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(1'b0, e.tag, "missing release", 0, e.mask);
      end else begin
        chk(1'b1, quiet_tag, "silence", 0, 0);
      end
    end
  end

  task automatic arrive(input int bar, input int szm1, input int core, input string tag);
    int slot;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2", "ready before arrival", int'(req_ready), 1);
    quiet_tag   = tag;
    req_valid   = 1'b1;
    req_bar     = BW'(bar);
    req_size_m1 = SW'(szm1);
    req_core    = CW'(core);
    slot = core % NC;
    if (!model[bar][slot]) begin
      model[bar][slot] = 1'b1;
      if ($countones(model[bar]) == szm1 + 1) begin
        exp_t e;
        e.bar = bar; e.mask = int'(model[bar]); e.due = cyc + 1; e.tag = tag;
        sb_q.push_back(e);
        model[bar] = '0;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk(rel_valid == 1'b0, "R1", "release during reset", int'(rel_valid), 0);
    chk(req_ready == 1'b0, "R2", "ready during reset", int'(req_ready), 0);
    for (int b = 0; b < NB; b++) model[b] = '0;
    sb_q.delete();
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    for (int b = 0; b < NB; b++) model[b] = '0;
    do_reset();

    // R1: stale arrival before reset must not survive
    arrive(0, 3, 0, "R4");
    idle(2);
    do_reset();
    arrive(0, 0, 1, "R1");
    idle(2);

    // R4 / R5: three-core rendezvous, release on the last arrival only
    arrive(2, 2, 0, "R4");
    arrive(2, 2, 1, "R4");
    arrive(2, 2, 2, "R5");
    idle(2);

    // R3: global core numbers fold modulo the core count
    arrive(3, 1, 5, "R3");
    arrive(3, 1, 10, "R3");
    arrive(1, 0, 255, "R3");
    idle(2);

    // R8: duplicate whose target would already be met is ignored
    arrive(4, 1, 3, "R4");
    arrive(4, 0, 3, "R8");
    idle(3);
    arrive(4, 1, 0, "R8");
    idle(2);

    // R6: barrier 2 reused after its release starts empty
    arrive(2, 0, 3, "R6");
    idle(2);

    // R7: interleaved barriers, request during another release
    arrive(5, 1, 0, "R7");
    arrive(6, 1, 1, "R7");
    arrive(5, 1, 2, "R7");
    arrive(6, 1, 3, "R7");
    arrive(7, 3, 0, "R7");
    arrive(7, 3, 1, "R7");
    arrive(7, 3, 2, "R7");
    arrive(7, 3, 3, "R5");
    idle(4);

    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(1'b0, e.tag, "release never seen", 0, e.mask);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule